// File: doc/BRIEF.md
# Page-Mapped Flash Translation Controller with Greedy Reclaim

This block places a logical page address space on top of a small modelled flash array organised as erase blocks of pages. Flash cells only move from one to zero when programmed and return to all ones only through a whole-block erase. For that reason, every host write lands on the next erased page of an open write block. A logical-to-physical map is then repointed, and the page that held the previous copy is marked stale. A trim request drops a mapping without touching the stored bits.

The physical array is larger than the logical space, and that spare share is never exposed to the host. When the pool of erased blocks shrinks to the reserve threshold, the controller stops accepting requests. It reclaims space by choosing the fully written block with the fewest live pages, copying those pages forward, and erasing the block. It repeats this until the pool is above the threshold again. Three counters expose host page writes, relocation page writes and block erases, so that write amplification can be computed outside. A raw physical read port shows the array contents directly, so the effects of stale data and erasure can be inspected.

Top module: `page_map_ftl`

## Requirements
- R1: After reset every logical page is unmapped, all counters read zero, `req_ready` is high and every physical page reads all ones with its erased flag set.
- R2: A read is accepted on a cycle with `req_valid` and `req_ready` both high and `req_op` = 0. It answers with `rsp_valid` high on the following cycle. An unmapped page answers with all-ones data and `rsp_unmapped` high.
- R3: A read of a written logical page returns its most recent data with `rsp_unmapped` low. Each accepted write (`req_op` = 1) raises `host_writes` by one.
- R4: Writes, including relocations, fill pages of the open block in ascending page order. Block 0 is open after reset. When the last page of the open block is filled, the lowest-numbered erased free block opens next.
- R5: A trim (`req_op` = 2) unmaps the logical page, and later reads answer as in R2. The stale physical copy keeps its bits until its block is erased.
- R6: When the count of free erased blocks is at or below `GC_THRESHOLD`, `req_ready` is low from the edge that caused it until reclaim has restored the count above the threshold. No host write is accepted meanwhile.
- R7: The reclaim victim is the fully written, non-open, non-free block with the fewest valid pages. Ties go to the lowest block index.
- R8: Every valid page of the victim is copied to the write frontier and its logical mapping follows it. Each copy raises `reloc_writes` by one and leaves `host_writes` unchanged.
- R9: Erasing the victim returns all its pages to all ones with erased flags set, makes the block free, and raises `block_erases` by one.
- R10: A page is programmed only while erased. An overwrite never reprograms the page holding the old copy, and that page keeps its old bits until erased.
- R11: All logical pages read back their latest written data after any number of reclaim passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 write, 2 trim, 3 ignored |
| req_lpa | input | LW | Logical page address |
| req_data | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted this cycle if valid |
| rsp_valid | output | 1 | Read answer present |
| rsp_data | output | DATA_W | Read data (all ones when unmapped) |
| rsp_unmapped | output | 1 | Read addressed an unmapped page |
| raw_blk | input | BW | Raw inspection block index |
| raw_pg | input | PW | Raw inspection page index |
| raw_data | output | DATA_W | Stored bits of the inspected page |
| raw_erased | output | 1 | Inspected page is in the erased state |
| host_writes | output | CNT_W | Accepted host page writes |
| reloc_writes | output | CNT_W | Relocation page writes |
| block_erases | output | CNT_W | Block erases performed |

## Verification
The clocked properties check the local rules on every cycle. A page is programmed only while erased. An erase leaves the whole block clean on the next cycle. A read answers one cycle after acceptance and each accepted write bumps the host counter. The relocation counter stays still outside reclaim, the host counter stays still during it, and the chosen victim is always an eligible block. Other behaviours only show in the bench's scenarios, seen through the raw port and the read answers. These are the greedy choice between blocks with equal live counts, stale data surviving a trim until its block is erased, the exact placement order on the write frontier, and data surviving relocation.

// File: rtl/ftl_pkg.sv
package ftl_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_TRIM  = 2'd2,
        OP_NONE  = 2'd3
    } ftl_op_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_GC_MOVE  = 2'd1,
        ST_GC_ERASE = 2'd2
    } ftl_state_e;

endpackage

// File: rtl/ftl_flash_array.sv
module ftl_flash_array #(
    parameter int NUM_BLOCKS      = 8,
    parameter int PAGES_PER_BLOCK = 4,
    parameter int DATA_W          = 8,
    localparam int BW = $clog2(NUM_BLOCKS),
    localparam int PW = $clog2(PAGES_PER_BLOCK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic [BW-1:0]     prog_blk,
    input  logic [PW-1:0]     prog_pg,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_en,
    input  logic [BW-1:0]     erase_blk,
    input  logic [BW-1:0]     rd_blk,
    input  logic [PW-1:0]     rd_pg,
    output logic [DATA_W-1:0] rd_data,
    input  logic [BW-1:0]     raw_blk,
    input  logic [PW-1:0]     raw_pg,
    output logic [DATA_W-1:0] raw_data,
    output logic              raw_erased
);

    logic [DATA_W-1:0]          cells_q  [NUM_BLOCKS][PAGES_PER_BLOCK];
    logic [PAGES_PER_BLOCK-1:0] erased_q [NUM_BLOCKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NUM_BLOCKS; b++) begin
                erased_q[b] <= '1;
                for (int p = 0; p < PAGES_PER_BLOCK; p++) cells_q[b][p] <= '1;
            end
        end else begin
            // bits may only fall from one to zero; a used page is refused
            if (prog_en && erased_q[prog_blk][prog_pg]) begin
                cells_q[prog_blk][prog_pg]  <= cells_q[prog_blk][prog_pg] & prog_data;
                erased_q[prog_blk][prog_pg] <= 1'b0;
            end
            if (erase_en) begin
                erased_q[erase_blk] <= '1;
                for (int p = 0; p < PAGES_PER_BLOCK; p++) cells_q[erase_blk][p] <= '1;
            end
        end
    end

    assign rd_data    = cells_q[rd_blk][rd_pg];
    assign raw_data   = cells_q[raw_blk][raw_pg];
    assign raw_erased = erased_q[raw_blk][raw_pg];

    assert_prog_erased_R10: assert property (@(posedge clk) disable iff (rst)
        prog_en |-> erased_q[prog_blk][prog_pg]);

    assert_erase_clean_R9: assert property (@(posedge clk) disable iff (rst)
        (erase_en && !prog_en) |=> (erased_q[$past(erase_blk)] == '1));

endmodule

// File: rtl/ftl_victim_pick.sv
module ftl_victim_pick #(
    parameter int NUM_BLOCKS      = 8,
    parameter int PAGES_PER_BLOCK = 4,
    localparam int BW = $clog2(NUM_BLOCKS),
    localparam int VW = $clog2(PAGES_PER_BLOCK + 1)
) (
    input  logic [VW-1:0]         live_cnt [NUM_BLOCKS],
    input  logic [NUM_BLOCKS-1:0] eligible,
    output logic [BW-1:0]         victim,
    output logic                  found
);

    logic [VW-1:0] best;

    // ascending scan with strict compare keeps the lowest index on ties
    always_comb begin
        victim = '0;
        found  = 1'b0;
        best   = '1;
        for (int b = 0; b < NUM_BLOCKS; b++) begin
            if (eligible[b] && (!found || live_cnt[b] < best)) begin
                victim = BW'(b);
                best   = live_cnt[b];
                found  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/page_map_ftl.sv
module page_map_ftl
    import ftl_pkg::*;
#(
    parameter int NUM_BLOCKS      = 8,
    parameter int PAGES_PER_BLOCK = 4,
    parameter int LOGICAL_PAGES   = 16,
    parameter int DATA_W          = 8,
    parameter int CNT_W           = 16,
    parameter int GC_THRESHOLD    = 1,
    localparam int BW = $clog2(NUM_BLOCKS),
    localparam int PW = $clog2(PAGES_PER_BLOCK),
    localparam int LW = $clog2(LOGICAL_PAGES),
    localparam int VW = $clog2(PAGES_PER_BLOCK + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [LW-1:0]     req_lpa,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_unmapped,
    input  logic [BW-1:0]     raw_blk,
    input  logic [PW-1:0]     raw_pg,
    output logic [DATA_W-1:0] raw_data,
    output logic              raw_erased,
    output logic [CNT_W-1:0]  host_writes,
    output logic [CNT_W-1:0]  reloc_writes,
    output logic [CNT_W-1:0]  block_erases
);

    typedef struct packed {
        logic          mapped;
        logic [BW-1:0] blk;
        logic [PW-1:0] pg;
    } map_entry_t;

    localparam logic [PW-1:0] LAST_PG = PW'(PAGES_PER_BLOCK - 1);

    ftl_state_e state_q;
    ftl_op_e    op;

    map_entry_t                 l2p_q   [LOGICAL_PAGES];
    logic [LW-1:0]              p2l_q   [NUM_BLOCKS][PAGES_PER_BLOCK];
    logic [PAGES_PER_BLOCK-1:0] valid_q [NUM_BLOCKS];
    logic [NUM_BLOCKS-1:0]      free_q;
    logic [BW-1:0]              act_blk_q, vic_q, first_free, victim;
    logic [PW-1:0]              act_pg_q, scan_q;
    logic [BW:0]                free_cnt;
    logic [VW-1:0]              live_cnt [NUM_BLOCKS];
    logic [NUM_BLOCKS-1:0]      eligible;
    logic                       vic_found, host_acc, need_gc;
    map_entry_t                 cur_map;

    logic              prog_en, erase_en;
    logic [BW-1:0]     prog_blk, erase_blk, rd_blk;
    logic [PW-1:0]     prog_pg, rd_pg;
    logic [DATA_W-1:0] prog_data, rd_data;

    assign op       = ftl_op_e'(req_op);
    assign free_cnt = (BW+1)'($countones(free_q));
    assign need_gc  = free_cnt <= (BW+1)'(GC_THRESHOLD);
    assign req_ready = (state_q == ST_IDLE) && !need_gc;
    assign host_acc  = req_valid && req_ready;
    assign cur_map   = l2p_q[req_lpa];

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
        assign live_cnt[g] = VW'($countones(valid_q[g]));
        assign eligible[g] = !free_q[g] && (act_blk_q != BW'(g));
    end

    always_comb begin
        first_free = '0;
        for (int b = NUM_BLOCKS - 1; b >= 0; b--)
            if (free_q[b]) first_free = BW'(b);
    end

    ftl_victim_pick #(
        .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK)
    ) u_pick (
        .live_cnt(live_cnt), .eligible(eligible), .victim(victim), .found(vic_found)
    );

    // flash command steering
    always_comb begin
        prog_en   = 1'b0;
        prog_blk  = act_blk_q;
        prog_pg   = act_pg_q;
        prog_data = req_data;
        erase_en  = 1'b0;
        erase_blk = vic_q;
        rd_blk    = cur_map.blk;
        rd_pg     = cur_map.pg;
        unique case (state_q)
            ST_GC_MOVE: begin
                rd_blk    = vic_q;
                rd_pg     = scan_q;
                prog_en   = valid_q[vic_q][scan_q];
                prog_data = rd_data;
            end
            ST_GC_ERASE: erase_en = 1'b1;
            default:     prog_en  = host_acc && (op == OP_WRITE);
        endcase
    end

    ftl_flash_array #(
        .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .DATA_W(DATA_W)
    ) u_array (
        .clk(clk), .rst(rst),
        .prog_en(prog_en), .prog_blk(prog_blk), .prog_pg(prog_pg), .prog_data(prog_data),
        .erase_en(erase_en), .erase_blk(erase_blk),
        .rd_blk(rd_blk), .rd_pg(rd_pg), .rd_data(rd_data),
        .raw_blk(raw_blk), .raw_pg(raw_pg), .raw_data(raw_data), .raw_erased(raw_erased)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            act_blk_q    <= '0;
            act_pg_q     <= '0;
            vic_q        <= '0;
            scan_q       <= '0;
            free_q       <= {{(NUM_BLOCKS-1){1'b1}}, 1'b0};
            rsp_valid    <= 1'b0;
            rsp_data     <= '1;
            rsp_unmapped <= 1'b0;
            host_writes  <= '0;
            reloc_writes <= '0;
            block_erases <= '0;
            for (int l = 0; l < LOGICAL_PAGES; l++) l2p_q[l] <= '0;
            for (int b = 0; b < NUM_BLOCKS; b++) begin
                valid_q[b] <= '0;
                for (int p = 0; p < PAGES_PER_BLOCK; p++) p2l_q[b][p] <= '0;
            end
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (host_acc) begin
                        unique case (op)
                            OP_READ: begin
                                rsp_valid    <= 1'b1;
                                rsp_data     <= cur_map.mapped ? rd_data : '1;
                                rsp_unmapped <= !cur_map.mapped;
                            end
                            OP_WRITE: begin
                                if (cur_map.mapped) valid_q[cur_map.blk][cur_map.pg] <= 1'b0;
                                p2l_q[act_blk_q][act_pg_q] <= req_lpa;
                                l2p_q[req_lpa] <= map_entry_t'({1'b1, act_blk_q, act_pg_q});
                                host_writes <= host_writes + CNT_W'(1);
                            end
                            OP_TRIM: begin
                                if (cur_map.mapped) valid_q[cur_map.blk][cur_map.pg] <= 1'b0;
                                l2p_q[req_lpa].mapped <= 1'b0;
                            end
                            default: ;
                        endcase
                    end else if (need_gc) begin
                        vic_q   <= victim;
                        scan_q  <= '0;
                        state_q <= ST_GC_MOVE;
                    end
                end
                ST_GC_MOVE: begin
                    if (valid_q[vic_q][scan_q]) begin
                        valid_q[vic_q][scan_q] <= 1'b0;
                        p2l_q[act_blk_q][act_pg_q] <= p2l_q[vic_q][scan_q];
                        l2p_q[p2l_q[vic_q][scan_q]] <= map_entry_t'({1'b1, act_blk_q, act_pg_q});
                        reloc_writes <= reloc_writes + CNT_W'(1);
                    end
                    if (scan_q == LAST_PG) state_q <= ST_GC_ERASE;
                    else                   scan_q  <= scan_q + PW'(1);
                end
                ST_GC_ERASE: begin
                    free_q[vic_q]  <= 1'b1;
                    valid_q[vic_q] <= '0;
                    block_erases   <= block_erases + CNT_W'(1);
                    state_q        <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
            // write frontier: the new copy becomes live, the block closes on its last page
            if (prog_en) begin
                valid_q[act_blk_q][act_pg_q] <= 1'b1;
                if (act_pg_q == LAST_PG) begin
                    act_blk_q          <= first_free;
                    free_q[first_free] <= 1'b0;
                    act_pg_q           <= '0;
                end else begin
                    act_pg_q <= act_pg_q + PW'(1);
                end
            end
        end
    end

    assert_read_answer_R2: assert property (@(posedge clk) disable iff (rst)
        (host_acc && op == OP_READ) |=> rsp_valid);

    assert_host_count_R3: assert property (@(posedge clk) disable iff (rst)
        (host_acc && op == OP_WRITE) |=> host_writes == $past(host_writes) + CNT_W'(1));

    assert_no_host_in_gc_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(host_writes));

    assert_victim_legal_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && need_gc) |-> (vic_found && eligible[victim]));

    assert_reloc_only_gc_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> $stable(reloc_writes));

endmodule

// File: tb/page_map_ftl_test.sv
module page_map_ftl_test;

    localparam int DW = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [3:0] req_lpa = '0;
    logic [7:0] req_data = '0;
    logic       req_ready, rsp_valid, rsp_unmapped, raw_erased;
    logic [7:0] rsp_data, raw_data;
    logic [2:0] raw_blk = '0;
    logic [1:0] raw_pg = '0;
    logic [15:0] host_writes, reloc_writes, block_erases;

    always #10 clk = ~clk;

    page_map_ftl uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(req_op), .req_lpa(req_lpa), .req_data(req_data),
        .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_unmapped(rsp_unmapped),
        .raw_blk(raw_blk), .raw_pg(raw_pg), .raw_data(raw_data), .raw_erased(raw_erased),
        .host_writes(host_writes), .reloc_writes(reloc_writes), .block_erases(block_erases)
    );

    int checks = 0;
    int failures = 0;
    int seq = 0;
    logic [7:0] exp_data [16];
    logic       exp_map  [16];
    logic [8:0] scoreboard [$];   // {unmapped, data}
    string      sb_req [$];

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ready();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic issue(logic [1:0] op, int lpa, logic [7:0] d);
        wait_ready();
        req_valid = 1'b1;
        req_op    = op;
        req_lpa   = 4'(lpa);
        req_data  = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(int lpa);
        seq++;
        exp_data[lpa] = 8'(seq);
        exp_map[lpa]  = 1'b1;
        issue(2'd1, lpa, 8'(seq));
    endtask

    task automatic do_trim(int lpa);
        exp_map[lpa] = 1'b0;
        issue(2'd2, lpa, 8'h00);
    endtask

    task automatic do_read(int lpa, string req);
        scoreboard.push_back(exp_map[lpa] ? {1'b0, exp_data[lpa]} : {1'b1, 8'hFF});
        sb_req.push_back(req);
        issue(2'd0, lpa, 8'h00);
    endtask

    task automatic raw_check(string req, int blk, int pg, int exp_d, int exp_e);
        raw_blk = 3'(blk);
        raw_pg  = 2'(pg);
        #1;
        check(req, raw_data, exp_d);
        check(req, raw_erased, exp_e);
    endtask

    // monitor: compare each answer with the oldest expected item
    always @(negedge clk) begin
        if (rsp_valid) begin
            if (scoreboard.size() == 0) begin
                check("R2 unexpected answer", 1, 0);
            end else begin
                logic [8:0] e;
                string r;
                e = scoreboard.pop_front();
                r = sb_req.pop_front();
                check(r, rsp_data, e[7:0]);
                check(r, rsp_unmapped, e[8]);
            end
        end
    end

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin exp_data[i] = 8'hFF; exp_map[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 ready", req_ready, 1);
        check("R1 host count", host_writes, 0);
        check("R1 reloc count", reloc_writes, 0);
        check("R1 erase count", block_erases, 0);
        raw_check("R1 raw erased", 0, 0, 8'hFF, 1);
        raw_check("R1 raw erased", 7, 3, 8'hFF, 1);
        do_read(3, "R2 unmapped read");

        // fill blocks 0..3 with lpa 0..15
        for (int l = 0; l < 16; l++) do_write(l);
        check("R3 host count", host_writes, 16);
        do_read(5, "R3 read back");
        do_read(15, "R3 read back");
        raw_check("R4 frontier order", 3, 3, 16, 0);

        // overwrites leave blocks 1 and 2 with one live page each, block 0 with two
        do_write(4); do_write(5); do_write(6); do_write(8);
        do_write(9); do_write(10); do_write(0);
        check("R6 ready before threshold", req_ready, 1);
        do_write(1);
        check("R6 stall on reclaim", req_ready, 0);
        raw_check("R4 R10 old copy kept", 0, 0, 1, 0);
        raw_check("R4 new copy placed", 5, 2, 23, 0);
        wait_ready();

        check("R8 host count unchanged", host_writes, 24);
        check("R8 reloc count", reloc_writes, 1);
        check("R9 erase count", block_erases, 1);
        for (int p = 0; p < 4; p++) raw_check("R7 R9 tie victim erased", 1, p, 8'hFF, 1);
        raw_check("R7 tie loser kept", 2, 3, 12, 0);
        raw_check("R8 relocated copy", 6, 0, 8, 0);
        do_read(7, "R8 mapping follows copy");

        // trim keeps the stale bits
        do_trim(11);
        do_read(11, "R5 trimmed read");
        raw_check("R5 stale bits remain", 2, 3, 12, 0);

        do_write(12); do_write(13);
        do_write(14);
        check("R6 stall second reclaim", req_ready, 0);
        wait_ready();
        raw_check("R4 frontier last page", 6, 3, 27, 0);
        raw_check("R5 R9 stale gone", 2, 3, 8'hFF, 1);
        check("R7 empty victim no copy", reloc_writes, 1);
        check("R9 erase count", block_erases, 2);
        check("R3 host count", host_writes, 27);

        for (int l = 0; l < 16; l++) do_read(l, "R11 integrity");
        repeat (3) @(negedge clk);
        check("R2 all answers seen", scoreboard.size(), 0);
        report();
    end

endmodule